// File: doc/BRIEF.md
# Eight-Slot TDM Frame Sync Generator

This block produces the timing that lets up to eight serial PCM codecs share one data line. It divides a fast system clock down to the bus bit rate. It then counts bits into 8-bit timeslots and slots into frames. For each codec it drives a sync pulse that marks the first bit of that codec's own slot. Each codec transmits only inside its slot and leaves the shared line released outside it.

At the default sizes, a 512 kHz bit rate gives 64 bit periods per frame, which is one 125 us frame. The pulses are produced by a one-hot token register that rotates from channel to channel once per slot. Each pulse lasts exactly one bit period. Test logic can use a one-clock frame strobe. A bus monitor can watch the slot and bit indices.

Top module: `tdm_sync_gen`

## Requirements
- R1: `bit_en` is high for exactly one system clock out of every `CLK_DIV` (default 4). It falls on the last clock of each bit period.
- R2: `bit_idx` holds its value through a bit period. On the clock after each `bit_en` it steps up by one, wrapping from `BITS-1` (7) to 0.
- R3: `slot_idx` changes only on the clock after a `bit_en` at bit 7. It then steps up by one, wrapping from `SLOTS-1` (7) to 0.
- R4: Bit k of `sync` (channel k+1) is high exactly while `slot_idx` equals k and `bit_idx` is 0. That is one full bit period of `CLK_DIV` clocks. At most one bit of `sync` is ever high.
- R5: The sync pulses follow one another in the fixed order bit 0, bit 1, ... bit 7, one per slot. After bit 7, bit 0 follows again in the next frame, 64 bit periods after its previous pulse.
- R6: `frame_start` is high for exactly one system clock: the first clock of slot 0, bit 0.
- R7: While `rst_n` is low, `bit_en`, `sync`, `frame_start`, `slot_idx` and `bit_idx` are all 0, without waiting for a clock edge. After `rst_n` rises, the outputs stay 0 for the first clock edge. From the second clock edge the frame begins at slot 0, bit 0, with `sync` bit 0 (channel 1) as the first pulse.
- R8: Pulling `rst_n` low in the middle of a frame abandons that frame. After release, timing restarts at slot 0, bit 0, exactly as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_DIV` times the bus bit rate |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| bit_en | output | 1 | One-clock strobe at the end of each bit period |
| sync | output | SLOTS (8) | Per-channel frame sync; bit k serves channel k+1 |
| slot_idx | output | clog2(SLOTS) (3) | Index of the slot in progress |
| bit_idx | output | clog2(BITS) (2..0 → 3) | Index of the bit in progress within its slot |
| frame_start | output | 1 | One-clock strobe at the first clock of each frame |

## Verification
The hardest case to reach from the ports is a reset that arrives in the middle of a frame. Here the token register, the bit counter and the divider all sit at non-zero values. The design must abandon every one of them at once and then restart at channel 1 after the synchronizer delay. The stimulus runs 150 bit periods, which stops part-way through a slot of the third frame. It pulls reset low off the clock edge and checks the outputs before any edge arrives. It then replays the schedule from zero, so the restart is compared cycle by cycle against a fresh frame.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;

  // Width of a counter that holds values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tdm_bit_div.sv
module tdm_bit_div #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_ni,
  output logic bit_en_o,
  output logic first_clk_o
);

  localparam int unsigned DW = tdm_sync_pkg::cnt_w(CLK_DIV);
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  assign wrap = (div_q == LAST);

  always_comb begin
    div_d = div_q + DW'(1);
    if (wrap) div_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign bit_en_o    = rst_ni & wrap;
  assign first_clk_o = (div_q == '0);

  // R1: a bit strobe is never followed directly by another one
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);

endmodule

// File: rtl/tdm_pos_cnt.sv
module tdm_pos_cnt #(
  parameter int unsigned BITS  = 8,
  parameter int unsigned SLOTS = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic [tdm_sync_pkg::cnt_w(BITS)-1:0]  bit_o,
  output logic [tdm_sync_pkg::cnt_w(SLOTS)-1:0] slot_o,
  output logic slot_adv_o
);

  localparam int unsigned BW = tdm_sync_pkg::cnt_w(BITS);
  localparam int unsigned SW = tdm_sync_pkg::cnt_w(SLOTS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          slot_end;

  assign slot_end = bit_en_i && (bit_q == BIT_LAST);

  always_comb begin
    bit_d  = bit_q;
    slot_d = slot_q;
    if (bit_en_i) begin
      bit_d = (bit_q == BIT_LAST) ? '0 : bit_q + BW'(1);
      if (slot_end) slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign bit_o      = bit_q;
  assign slot_o     = slot_q;
  assign slot_adv_o = slot_end;

  // R2: bit index holds between strobes
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable(bit_q));
  // R3: slot index moves only after the last bit of a slot
  a_r3_slot_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(slot_q) |-> ($past(bit_q) == BIT_LAST && $past(bit_en_i)));

endmodule

// File: rtl/tdm_sync_ring.sv
module tdm_sync_ring #(
  parameter int unsigned SLOTS = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic advance_i,
  input  logic bit_zero_i,
  input  logic [tdm_sync_pkg::cnt_w(SLOTS)-1:0] slot_i,
  output logic [SLOTS-1:0] sync_o
);

  logic [SLOTS-1:0] token_q, token_d;

  generate
    if (SLOTS > 1) begin : g_rot
      always_comb begin
        token_d = token_q;
        if (advance_i) token_d = {token_q[SLOTS-2:0], token_q[SLOTS-1]};
      end
    end else begin : g_single
      always_comb token_d = token_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) token_q <= SLOTS'(1);
    else         token_q <= token_d;
  end

  assign sync_o = (rst_ni && bit_zero_i) ? token_q : '0;

  // R4: at most one channel pulses at a time
  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(sync_o));
  // R4: token and slot counter agree
  a_r4_token_slot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot(token_q) && token_q[slot_i]);
  // R5: token only ever moves by one channel position
  a_r5_walk_order: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(token_q) |-> $countones(token_q & ($past(token_q) << 1)) == 1
                          || (token_q[0] && $past(token_q[SLOTS-1])));

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen #(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned BITS    = 8,
  localparam int unsigned SW = tdm_sync_pkg::cnt_w(SLOTS),
  localparam int unsigned BW = tdm_sync_pkg::cnt_w(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          bit_en,
  output logic [SLOTS-1:0] sync,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx,
  output logic          frame_start
);

  logic          rst_ni;
  logic          first_clk;
  logic          slot_adv;
  logic [BW-1:0] bit_w;
  logic [SW-1:0] slot_w;

  tdm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  tdm_bit_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .bit_en_o    (bit_en),
    .first_clk_o (first_clk)
  );

  tdm_pos_cnt #(.BITS(BITS), .SLOTS(SLOTS)) u_pos (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en),
    .bit_o      (bit_w),
    .slot_o     (slot_w),
    .slot_adv_o (slot_adv)
  );

  tdm_sync_ring #(.SLOTS(SLOTS)) u_ring (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .advance_i  (slot_adv),
    .bit_zero_i (bit_w == '0),
    .slot_i     (slot_w),
    .sync_o     (sync)
  );

  assign bit_idx     = bit_w;
  assign slot_idx    = slot_w;
  assign frame_start = rst_ni && first_clk && (bit_w == '0) && (slot_w == '0);

  // R6: the frame strobe lasts one clock
  a_r6_strobe_one_clk: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_start |=> !frame_start);
  // R6: the frame strobe coincides with the channel 1 pulse
  a_r6_with_first_sync: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_start |-> sync[0]);

endmodule

// File: tb/tdm_sync_gen_test.sv
module tdm_sync_gen_test;

  localparam int DIV = 4;
  localparam int NS  = 8;
  localparam int NB  = 8;

  typedef struct packed {
    logic       en;
    logic [7:0] sy;
    logic [2:0] sl;
    logic [2:0] bi;
    logic       fs;
  } exp_t;

  logic       clk, rst_n;
  logic       bit_en, frame_start;
  logic [7:0] sync;
  logic [2:0] slot_idx, bit_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  exp_t q[$];

  tdm_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync(sync),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_start(frame_start)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input int t);
    exp_t e;
    int dv, bp, bi, sl;
    dv = t % DIV;
    bp = t / DIV;
    bi = bp % NB;
    sl = (bp / NB) % NS;
    e.en = (dv == DIV - 1);
    e.bi = 3'(bi);
    e.sl = 3'(sl);
    e.sy = (bi == 0) ? 8'(1 << sl) : 8'h00;
    e.fs = (dv == 0) && (bi == 0) && (sl == 0);
    return e;
  endfunction

  // driver: the first state is the one just after the current edge
  task automatic drive(input int n);
    for (int t = 0; t < n; t++) begin
      if (t != 0) @(posedge clk);
      #1 q.push_back(model(t));
    end
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 bit_en", int'(bit_en), int'(e.en));
      chk("R2 bit_idx", int'(bit_idx), int'(e.bi));
      chk("R3 slot_idx", int'(slot_idx), int'(e.sl));
      chk("R4/R5 sync", int'(sync), int'(e.sy));
      chk("R6 frame_start", int'(frame_start), int'(e.fs));
    end
  end

  task automatic chk_idle(input string req);
    chk(req, int'({bit_en, sync, slot_idx, bit_idx, frame_start}), 0);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R7 outputs in reset");
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R7 held during sync window");
    @(posedge clk);
    // R7: channel 1 first, slot 0 bit 0
    drive(600);
    @(negedge clk);
    #2 rst_n = 0;
    #1 chk_idle("R8 async clear mid-frame");
    repeat (2) @(negedge clk);
    chk_idle("R8 held in reset");
    rst_n = 1;
    @(posedge clk);
    @(posedge clk);
    // R8: restart from slot 0 bit 0
    drive(300);
    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule